// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block converts a local-bus address into a bus-side address and a cycle type. Three programmable windows do the conversion. Each window has a base word and a map word. The base word says where the window sits in local space, how large it is and whether it is switched on. The map word says where the window lands on the bus side, which cycle type it produces and whether the two lowest address bits are carried through.

Windows may overlap. When more than one enabled window contains the address, the one with the lowest index provides the result. Software can enlarge window 0 to hide window 1, reprogram window 1 (for example as a configuration aperture), and later shrink window 0 again to expose it. The highest window serves I/O space only, so it always reports the I/O cycle type. The lookup path is purely combinational. Register writes land on the clock edge.

Top module: `addr_window_xlate`

## Requirements
- R1: Register writes are made with `cfg_we`. `cfg_win` selects the window and `cfg_is_map` selects the word (0 = base, 1 = map). The write lands on the next rising clock edge, so a lookup in the same cycle still sees the old contents. A write with `cfg_win` of 3 or more changes nothing.
- R2: Base word layout:
  - bit 0 enables the window;
  - bits 7:4 hold a size code, and the window spans 2^(20+code) bytes;
  - bits 31:20 give the window start in 1 MB units, aligned down to the window size;
  - a size code of 12 or more covers the whole 4 GB space.
- R3: A disabled window never matches, whatever address is presented.
- R4: Windows are checked in ascending index order. The first enabled window that contains the address supplies every output, even when a higher window also contains it.
- R5: On a hit, the translated address takes its bits above the window size from map bits 31:20 (1 MB units) and its bits below the window size from the local address.
- R6: On a hit in window 0 or 1, `lk_ctype` equals map bits 3:1 unchanged. Code 3'b101 is the configuration cycle.
- R7: A hit in window 2 always reports cycle type 3'b001 (I/O), whatever its map type field holds.
- R8: Map bit 0 is the low-address enable. When it is set, translated bits 1:0 equal local bits 1:0. When it is clear, they are 00. `lk_alow` reflects this bit for the winning window.
- R9: On a miss, `lk_hit`, `lk_addr`, `lk_ctype` and `lk_alow` are all zero. After reset every window is disabled, so every lookup misses.
- R10: Growing window 0 to cover window 1's range hides window 1 there. Shrinking window 0 back makes window 1's translation visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window index for the write |
| cfg_is_map | input | 1 | 0 selects the base word, 1 selects the map word |
| cfg_wdata | input | 32 | Write data |
| lk_addr_in | input | 32 | Local address to translate |
| lk_hit | output | 1 | Some enabled window contains the address |
| lk_addr | output | 32 | Translated bus address |
| lk_ctype | output | 3 | Cycle type of the winning window |
| lk_alow | output | 1 | Low-address enable of the winning window |

## Verification
The hardest situation to reach is an address that several enabled windows contain at once, each with a different size and map. Only there can a wrong priority order, or a wrong mask width, show up at the outputs.

Random programming with independent bases seldom produces such overlaps. So the random stimulus draws window starts from a small pool of 256 MB-aligned regions and draws lookup addresses near a programmed start.

A directed sequence then replays the enlarge, remap and shrink cycle. It checks the address in the shared range before, during and after the cycle, and also checks it in the same cycle as the write that changes the answer.

// File: rtl/awx_pkg.sv
package awx_pkg;
  localparam int AW     = 32;
  localparam int GRAN   = 20;
  localparam int CODE_W = 4;
  localparam int CT_W   = 3;
  localparam logic [CT_W-1:0] CT_IO  = 3'b001;
  localparam logic [CT_W-1:0] CT_CFG = 3'b101;
  localparam int MAX_CODE = AW - GRAN;

  typedef struct packed {
    logic          hit;
    logic [AW-1:0] addr;
    logic [CT_W-1:0] ctype;
    logic          alow;
  } xlate_t;

  // Offset mask of a window: ones below the window size.
  function automatic logic [AW-1:0] size_mask(input logic [CODE_W-1:0] code);
    logic [AW-1:0] one;
    one = {{(AW-1){1'b0}}, 1'b1};
    if (int'(code) >= MAX_CODE) return '1;
    return (one << (GRAN + int'(code))) - one;
  endfunction

  function automatic logic in_window(input logic [AW-1:0] base_w,
                                     input logic [AW-1:0] addr);
    logic [AW-1:0] m;
    m = size_mask(base_w[7:4]);
    return base_w[0] && ((addr & ~m) == ({base_w[AW-1:GRAN], {GRAN{1'b0}}} & ~m));
  endfunction

  function automatic logic [AW-1:0] remap(input logic [AW-1:0] base_w,
                                          input logic [AW-1:0] map_w,
                                          input logic [AW-1:0] addr);
    logic [AW-1:0] m;
    logic [AW-1:0] r;
    m = size_mask(base_w[7:4]);
    r = ({map_w[AW-1:GRAN], {GRAN{1'b0}}} & ~m) | (addr & m);
    if (!map_w[0]) r[1:0] = 2'b00;
    return r;
  endfunction
endpackage

// File: rtl/awx_regfile.sv
module awx_regfile #(
  parameter int NUM_WIN = 3,
  parameter int SEL_W   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [SEL_W-1:0]                   win,
  input  logic                               is_map,
  input  logic [awx_pkg::AW-1:0]             wdata,
  output logic [NUM_WIN-1:0][awx_pkg::AW-1:0] base_q,
  output logic [NUM_WIN-1:0][awx_pkg::AW-1:0] map_q
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_reg
    logic sel_here;
    assign sel_here = we && (int'(win) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        map_q[i]  <= '0;
      end else if (sel_here) begin
        if (is_map) map_q[i]  <= wdata;
        else        base_q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/awx_win_match.sv
module awx_win_match #(
  parameter bit IO_ONLY = 1'b0
) (
  input  logic [awx_pkg::AW-1:0] base_w,
  input  logic [awx_pkg::AW-1:0] map_w,
  input  logic [awx_pkg::AW-1:0] addr,
  output awx_pkg::xlate_t        res
);
  import awx_pkg::*;
  always_comb begin
    res.hit   = in_window(base_w, addr);
    res.addr  = remap(base_w, map_w, addr);
    res.alow  = map_w[0];
    res.ctype = IO_ONLY ? CT_IO : map_w[3:1];
  end
endmodule

// File: rtl/awx_prio_sel.sv
module awx_prio_sel #(
  parameter int NUM_WIN = 3,
  parameter int SEL_W   = 2
) (
  input  awx_pkg::xlate_t [NUM_WIN-1:0] cand,
  output logic [NUM_WIN-1:0]            hit_vec,
  output logic [SEL_W-1:0]              win_sel,
  output awx_pkg::xlate_t               out
);
  always_comb begin
    out     = '0;
    win_sel = '0;
    for (int i = 0; i < NUM_WIN; i++) hit_vec[i] = cand[i].hit;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (cand[i].hit) begin
        out     = cand[i];
        win_sel = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int NUM_WIN = 3,
  parameter int SEL_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [SEL_W-1:0]            cfg_win,
  input  logic                        cfg_is_map,
  input  logic [awx_pkg::AW-1:0]      cfg_wdata,
  input  logic [awx_pkg::AW-1:0]      lk_addr_in,
  output logic                        lk_hit,
  output logic [awx_pkg::AW-1:0]      lk_addr,
  output logic [awx_pkg::CT_W-1:0]    lk_ctype,
  output logic                        lk_alow
);
  import awx_pkg::*;

  logic [NUM_WIN-1:0][AW-1:0] base_q;
  logic [NUM_WIN-1:0][AW-1:0] map_q;
  xlate_t [NUM_WIN-1:0]       cand;
  logic [NUM_WIN-1:0]         hit_vec;
  logic [SEL_W-1:0]           win_sel;
  xlate_t                     chosen;

  awx_regfile #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .win(cfg_win),
    .is_map(cfg_is_map), .wdata(cfg_wdata),
    .base_q(base_q), .map_q(map_q)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    awx_win_match #(.IO_ONLY(i == NUM_WIN - 1)) u_match (
      .base_w(base_q[i]), .map_w(map_q[i]), .addr(lk_addr_in), .res(cand[i])
    );
  end

  awx_prio_sel #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_prio (
    .cand(cand), .hit_vec(hit_vec), .win_sel(win_sel), .out(chosen)
  );

  assign lk_hit   = chosen.hit;
  assign lk_addr  = chosen.addr;
  assign lk_ctype = chosen.ctype;
  assign lk_alow  = chosen.alow;
endmodule

// File: rtl/awx_checker.sv
module awx_checker #(
  parameter int NUM_WIN = 3,
  parameter int SEL_W   = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cfg_we,
  input logic [SEL_W-1:0]                   cfg_win,
  input logic                               cfg_is_map,
  input logic [awx_pkg::AW-1:0]             cfg_wdata,
  input logic [NUM_WIN-1:0][awx_pkg::AW-1:0] base_q,
  input logic [NUM_WIN-1:0]                 hit_vec,
  input logic [SEL_W-1:0]                   win_sel,
  input logic                               lk_hit,
  input logic [awx_pkg::AW-1:0]             lk_addr,
  input logic [awx_pkg::CT_W-1:0]           lk_ctype,
  input logic                               lk_alow
);
  AST_BASE_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_is_map && cfg_win == '0) |=> base_q[0] == $past(cfg_wdata)); // R1
  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !base_q[0][0] |-> !hit_vec[0]); // R3
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> (lk_hit && win_sel == '0)); // R4
  AST_IO_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && int'(win_sel) == NUM_WIN - 1) |-> lk_ctype == awx_pkg::CT_IO); // R7
  AST_LOW_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_alow) |-> lk_addr[1:0] == 2'b00); // R8
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> (!lk_hit && lk_addr == '0 && lk_ctype == '0 && !lk_alow)); // R9
endmodule

bind addr_window_xlate awx_checker #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
  .cfg_is_map(cfg_is_map), .cfg_wdata(cfg_wdata), .base_q(base_q),
  .hit_vec(hit_vec), .win_sel(win_sel), .lk_hit(lk_hit), .lk_addr(lk_addr),
  .lk_ctype(lk_ctype), .lk_alow(lk_alow)
);

// File: tb/addr_window_xlate_test.sv
module addr_window_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_win = '0;
  logic        cfg_is_map = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lk_addr_in = '0;
  logic        lk_hit;
  logic [31:0] lk_addr;
  logic [2:0]  lk_ctype;
  logic        lk_alow;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_base [3];
  logic [31:0] m_map  [3];

  always #2 clk = ~clk;

  addr_window_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_is_map(cfg_is_map), .cfg_wdata(cfg_wdata), .lk_addr_in(lk_addr_in),
    .lk_hit(lk_hit), .lk_addr(lk_addr), .lk_ctype(lk_ctype), .lk_alow(lk_alow)
  );

  function automatic logic [63:0] span(input logic [31:0] b);
    int c;
    c = int'(b[7:4]);
    if (c > 12) c = 12;
    return 64'd1 << (20 + c);
  endfunction

  // Expected {hit, addr, ctype, alow}
  function automatic logic [36:0] model(input logic [31:0] a);
    for (int w = 0; w < 3; w++) begin
      logic [63:0] sz, lo;
      logic [31:0] off, r;
      logic [2:0]  t;
      sz = span(m_base[w]);
      lo = {32'd0, m_base[w][31:20], 20'd0} & ~(sz - 64'd1);
      if (m_base[w][0] && {32'd0, a} >= lo && {32'd0, a} < lo + sz) begin
        off = a - lo[31:0];
        r = 32'(({32'd0, m_map[w][31:20], 20'd0} & ~(sz - 64'd1)) + {32'd0, off});
        if (!m_map[w][0]) r = {r[31:2], 2'b00};
        t = (w == 2) ? 3'b001 : m_map[w][3:1];
        return {1'b1, r, t, m_map[w][0]};
      end
    end
    return '0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] a);
    logic [36:0] e;
    @(negedge clk);
    lk_addr_in = a;
    #1;
    e = model(a);
    chk(req, {27'd0, lk_hit, lk_addr, lk_ctype, lk_alow}, {27'd0, e});
  endtask

  task automatic wr(input int w, input bit is_map, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 2'(w); cfg_is_map = is_map; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (w < 3) begin
      if (is_map) m_map[w] = d; else m_base[w] = d;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < 3; w++) begin m_base[w] = '0; m_map[w] = '0; end
    #9 rst_n = 1'b1;

    // R9: reset state misses everywhere
    look("R9 reset miss", 32'h4000_0000);
    look("R9 reset miss", 32'h0000_0000);

    // Standard layout
    wr(0, 0, 32'h4000_0081); wr(0, 1, 32'h0000_0006);   // 256MB, mem 011
    wr(1, 0, 32'h5000_0081); wr(1, 1, 32'h1000_000E);   // 256MB, type 111
    wr(2, 0, 32'h6000_0041); wr(2, 1, 32'h0000_000B);   // 16MB, map type 101 but IO-only
    look("R5 R6 window0", 32'h4123_4567);
    chk("R5 window0 addr", {32'd0, lk_addr}, {32'd0, 32'h0123_4564});
    look("R6 window1 type", 32'h5000_1234);
    chk("R6 window1 ctype", {61'd0, lk_ctype}, {61'd0, 3'b111});
    look("R7 window2 io", 32'h60AB_CDEF);
    chk("R7 io ctype", {61'd0, lk_ctype}, {61'd0, 3'b001});
    chk("R8 alow pass", {62'd0, lk_addr[1:0]}, {62'd0, 2'b11});
    look("R9 miss", 32'h6100_0000);
    chk("R9 miss hit", {63'd0, lk_hit}, 64'd0);

    // R10 / R4: enlarge window 0, remap window 1 as config
    wr(0, 0, 32'h4000_0091);
    look("R10 hidden", 32'h5000_1234);
    chk("R10 hidden ctype", {61'd0, lk_ctype}, {61'd0, 3'b011});
    wr(1, 0, 32'h6100_0041); wr(1, 1, 32'h0000_000A);
    look("R6 config", 32'h6100_0A07);
    chk("R6 config ctype", {61'd0, lk_ctype}, {61'd0, 3'b101});
    chk("R8 low forced", {32'd0, lk_addr}, {32'd0, 32'h0000_0A04});
    wr(1, 0, 32'h5000_0081); wr(1, 1, 32'h1000_000E);
    look("R4 still window0", 32'h5000_1234);

    // R1: same-cycle write sees old; next cycle new
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 2'd0; cfg_is_map = 1'b0; cfg_wdata = 32'h4000_0081;
    lk_addr_in = 32'h5000_1234;
    #1;
    chk("R1 old value", {61'd0, lk_ctype}, {61'd0, 3'b011});
    @(negedge clk);
    cfg_we = 1'b0; m_base[0] = 32'h4000_0081;
    #1;
    chk("R10 exposed", {61'd0, lk_ctype}, {61'd0, 3'b111});
    chk("R10 exposed addr", {32'd0, lk_addr}, {32'd0, 32'h1000_1234});

    // R1: out-of-range index ignored
    wr(3, 0, 32'h0000_00F1);
    look("R1 ignored idx", 32'h7000_0000);
    chk("R1 ignored hit", {63'd0, lk_hit}, 64'd0);

    // R3: disabled window
    wr(0, 0, 32'h4000_0080);
    look("R3 disabled", 32'h4000_0010);
    chk("R3 disabled hit", {63'd0, lk_hit}, 64'd0);

    // R2: whole-space code
    wr(2, 0, 32'h0000_00F1);
    look("R2 whole space", 32'hFEDC_BA98);
    chk("R2 whole hit", {63'd0, lk_hit}, 64'd1);

    // Random overlapping programming
    for (int i = 0; i < 600; i++) begin
      int w;
      logic [31:0] d;
      w = int'($urandom_range(0, 2));
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1) == 0) begin
          d = {4'h4 + 4'($urandom_range(0, 2)), 8'($urandom), 12'($urandom),
               4'($urandom_range(0, 13)), 3'($urandom), 1'($urandom_range(0, 5) != 0)};
          wr(w, 0, d);
        end else begin
          wr(w, 1, $urandom);
        end
      end else begin
        d = {m_base[w][31:20], 20'd0} + ($urandom & 32'h1FFF_FFFF);
        look("R4 R5 random", d);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule